// File: doc/BRIEF.md
# DDR Read Burst Output Sequencer

This block models the device side of a double-data-rate read path. Decoded READ commands arrive on the command clock. Each command carries a bank, a starting column and an auto-precharge flag. After a configurable CAS latency the block plays out the burst two elements per clock: `dq_rise` is the element launched on the rising edge and `dq_fall` the element launched on the falling edge. Alongside the data it drives a read strobe, a data output enable and a terminator-disable flag, all framed by the correct preamble and postamble. Burst data comes from a computed array model indexed by bank and column.

The read strobe is given as two half-cycle levels per clock. Bit 1 is the level in the first half and bit 0 the level in the second half. Bursts whose commands are spaced exactly one burst apart play out back to back, with no idle cycle and no extra strobe framing. A command that arrives too early, or that targets a bank still waiting for its auto precharge, is rejected and flagged. A burst already in flight always completes. For each auto-precharge read the block raises a one-cycle precharge pulse for that bank once the burst has ended and the minimum row-active time has passed.

Top module: `ddr_rd_burst_seq`

## Requirements
- R1: A READ accepted in cycle n, with `cfg_cas_lat` = CL (legal 5 to 9), drives `dq_oe` high in cycles n+CL through n+CL+BL/2-1. BL is 8 when `cfg_bl8`=1 and 4 otherwise. Each of these cycles carries two elements: element 2p on `dq_rise` and element 2p+1 on `dq_fall`, where p is the cycle's offset in the burst.
- R2: Element e of a burst that starts at column s reads column (s & ~(BL-1)) | ((s+e) & (BL-1)), so the columns wrap inside the BL-aligned block. Its data word is the zero-extended value {bank, column} XOR `DATA_SEED` (default 16'h5A00).
- R3: In every data cycle `rdqs_oe`=1 and `rdqs`=2'b10: high in the first half and low in the second half. The low half of the last data cycle is the postamble.
- R4: In the cycle just before a burst's first data cycle, unless that cycle carries data of the previous burst, `rdqs_oe`=1, `rdqs`=2'b00 and `dq_oe`=0. This is the preamble.
- R5: A READ accepted exactly BL/2 cycles after the previously accepted one starts its data in the cycle right after the previous burst's last data cycle. No preamble or idle cycle lies between the two bursts.
- R6: In any cycle that is neither a data cycle nor a preamble cycle, `dq_oe`, `rdqs_oe`, `rdqs`, `dq_rise` and `dq_fall` are all zero.
- R7: `odt_off` is high in exactly the data cycles and the preamble cycles.
- R8: A READ that arrives fewer than BL/2 cycles after the last accepted READ is ignored. `cmd_err` goes high in the following cycle, and the burst in flight runs to full length.
- R9: For an accepted READ in cycle n with `cmd_ap`=1, `prech[bank]` is high for exactly one cycle, in cycle max(n+CL+BL/2, n+`TRAS_MIN`).
- R10: A READ to a bank whose auto-precharge pulse has not yet occurred is ignored, and `cmd_err` goes high in the following cycle.
- R11: While `rst` is high, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cas_lat | input | CL_W (4) | CAS latency in cycles, 5 to 9 |
| cfg_bl8 | input | 1 | 1 selects burst length 8, 0 selects 4 |
| cmd_read | input | 1 | READ command valid this cycle |
| cmd_bank | input | BANK_W (2) | Bank of the READ |
| cmd_col | input | COL_W (8) | Starting column of the READ |
| cmd_ap | input | 1 | Auto precharge requested |
| dq_rise | output | DW (16) | Element driven on the rising clock edge |
| dq_fall | output | DW (16) | Element driven on the falling clock edge |
| dq_oe | output | 1 | Data output enable; low means high impedance |
| rdqs | output | 2 | Strobe level: bit 1 first half, bit 0 second half |
| rdqs_oe | output | 1 | Strobe output enable |
| odt_off | output | 1 | On-die terminators disabled |
| prech | output | NBANK (4) | One-cycle auto-precharge pulse per bank |
| cmd_err | output | 1 | The previous cycle's READ was rejected |

## Verification
Commands spaced exactly one burst apart test seamless joining. Spacing one cycle wider shows that a lone preamble cycle lands between the bursts and that the postamble ends the first burst. Spacing tighter than one burst exercises rejection and proves the running burst is not cut short. Start columns away from the block boundary, at both burst lengths, separate wrapping from plain incrementing. Auto-precharge reads at short and long CAS latency distinguish the row-active limit from the end-of-burst limit. A read to a bank still waiting for its pulse tests the pending-bank rejection. Random phases then mix latency, burst length, bank, column, precharge and command density.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

  typedef enum logic [1:0] {
    SLOT_IDLE,
    SLOT_PRE,
    SLOT_DATA
  } slot_e;

  localparam logic [1:0] STROBE_DATA = 2'b10;
  localparam logic [1:0] STROBE_PRE  = 2'b00;

  // clock cycles a burst occupies, minus one
  function automatic logic [1:0] pairs_left_init(input logic bl8);
    return bl8 ? 2'd3 : 2'd1;
  endfunction

  // minimum accepted command spacing in cycles (one whole burst)
  function automatic logic [2:0] min_spacing(input logic bl8);
    return bl8 ? 3'd4 : 3'd2;
  endfunction

endpackage

// File: rtl/rdseq_cmd_gate.sv
module rdseq_cmd_gate
  import rdseq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int NBANK  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_bl8,
  input  logic              cmd_read,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [NBANK-1:0]  bank_pend,
  output logic              accept,
  output logic              cmd_err
);

  logic [2:0] since_q;
  logic       space_ok;

  assign space_ok = since_q >= min_spacing(cfg_bl8);
  assign accept   = cmd_read && space_ok && !bank_pend[cmd_bank];

  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= 3'd4;
      cmd_err <= 1'b0;
    end else begin
      cmd_err <= cmd_read && !accept;
      if (accept)              since_q <= 3'd1;
      else if (since_q < 3'd4) since_q <= since_q + 3'd1;
    end
  end

  // R8: with BL8 two accepted commands are never on adjacent cycles
  assert_spacing_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_bl8 && accept) |=> !accept);

endmodule

// File: rtl/rdseq_delay_line.sv
module rdseq_delay_line #(
  parameter int W     = 11,
  parameter int DEPTH = 8,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [W-1:0]     in_data,
  input  logic [SEL_W-1:0] launch_tap,
  input  logic [SEL_W-1:0] pre_tap,
  output logic             launch_vld,
  output logic [W-1:0]     launch_data,
  output logic             pre_vld
);

  logic [DEPTH:1] vld_q;
  logic [W-1:0]   dat_q [DEPTH:1];

  generate
    for (genvar g = 1; g <= DEPTH; g++) begin : g_stage
      if (g == 1) begin : g_head
        always_ff @(posedge clk) begin
          vld_q[g] <= rst ? 1'b0 : in_vld;
          dat_q[g] <= in_data;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          vld_q[g] <= rst ? 1'b0 : vld_q[g-1];
          dat_q[g] <= dat_q[g-1];
        end
      end
    end
  endgenerate

  always_comb begin
    launch_vld  = 1'b0;
    launch_data = '0;
    pre_vld     = 1'b0;
    for (int i = 1; i <= DEPTH; i++) begin
      if (launch_tap == SEL_W'(i)) begin
        launch_vld  = vld_q[i];
        launch_data = dat_q[i];
      end
      if (pre_tap == SEL_W'(i)) pre_vld = vld_q[i];
    end
  end

endmodule

// File: rtl/rdseq_burst_engine.sv
module rdseq_burst_engine
  import rdseq_pkg::*;
#(
  parameter int             DW        = 16,
  parameter int             BANK_W    = 2,
  parameter int             COL_W     = 8,
  parameter logic [DW-1:0]  DATA_SEED = 16'h5A00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_bl8,
  input  logic              launch_vld,
  input  logic [BANK_W-1:0] launch_bank,
  input  logic [COL_W-1:0]  launch_col,
  input  logic              launch_ap,
  input  logic              pre_vld,
  output logic [DW-1:0]     dq_rise,
  output logic [DW-1:0]     dq_fall,
  output logic              dq_oe,
  output logic [1:0]        rdqs,
  output logic              rdqs_oe,
  output logic              odt_off,
  output logic              last_ap,
  output logic [BANK_W-1:0] last_bank
);

  logic [1:0]        rem_q;
  logic [2:0]        idx_q;
  logic [COL_W-1:0]  start_q;
  logic [BANK_W-1:0] bank_q;
  logic              ap_q;
  logic              last_q;

  slot_e             nslot;
  logic [1:0]        s_rem;
  logic [2:0]        s_idx;
  logic [COL_W-1:0]  s_start;
  logic [BANK_W-1:0] s_bank;
  logic              s_ap;
  logic [COL_W-1:0]  mask, col_a, col_b;

  // array model: one word per bank and column
  function automatic logic [DW-1:0] word_of(input logic [BANK_W-1:0] b,
                                            input logic [COL_W-1:0]  c);
    return DW'({b, c}) ^ DATA_SEED;
  endfunction

  always_comb begin
    nslot   = SLOT_IDLE;
    s_rem   = rem_q;
    s_idx   = idx_q;
    s_start = start_q;
    s_bank  = bank_q;
    s_ap    = ap_q;
    if (dq_oe && rem_q != 2'd0) begin
      nslot = SLOT_DATA;
      s_rem = rem_q - 2'd1;
    end else if (launch_vld) begin
      nslot   = SLOT_DATA;
      s_rem   = pairs_left_init(cfg_bl8);
      s_idx   = 3'd0;
      s_start = launch_col;
      s_bank  = launch_bank;
      s_ap    = launch_ap;
    end else if (pre_vld) begin
      nslot = SLOT_PRE;
    end
  end

  assign mask  = cfg_bl8 ? COL_W'(7) : COL_W'(3);
  assign col_a = (s_start & ~mask) | ((s_start + COL_W'(s_idx)) & mask);
  assign col_b = (s_start & ~mask) | ((s_start + COL_W'(s_idx + 3'd1)) & mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      idx_q   <= '0;
      start_q <= '0;
      bank_q  <= '0;
      ap_q    <= 1'b0;
      last_q  <= 1'b0;
      dq_rise <= '0;
      dq_fall <= '0;
      dq_oe   <= 1'b0;
      rdqs    <= STROBE_PRE;
      rdqs_oe <= 1'b0;
      odt_off <= 1'b0;
    end else begin
      case (nslot)
        SLOT_DATA: begin
          rem_q   <= s_rem;
          idx_q   <= s_idx + 3'd2;
          start_q <= s_start;
          bank_q  <= s_bank;
          ap_q    <= s_ap;
          last_q  <= (s_rem == 2'd0);
          dq_rise <= word_of(s_bank, col_a);
          dq_fall <= word_of(s_bank, col_b);
          dq_oe   <= 1'b1;
          rdqs    <= STROBE_DATA;
          rdqs_oe <= 1'b1;
          odt_off <= 1'b1;
        end
        SLOT_PRE: begin
          rem_q   <= '0;
          last_q  <= 1'b0;
          dq_rise <= '0;
          dq_fall <= '0;
          dq_oe   <= 1'b0;
          rdqs    <= STROBE_PRE;
          rdqs_oe <= 1'b1;
          odt_off <= 1'b1;
        end
        default: begin
          rem_q   <= '0;
          last_q  <= 1'b0;
          dq_rise <= '0;
          dq_fall <= '0;
          dq_oe   <= 1'b0;
          rdqs    <= STROBE_PRE;
          rdqs_oe <= 1'b0;
          odt_off <= 1'b0;
        end
      endcase
    end
  end

  assign last_ap   = dq_oe && last_q && ap_q;
  assign last_bank = bank_q;

  // R8: a new launch never lands inside a burst that still has cycles left
  assert_no_truncate_R8: assert property (@(posedge clk) disable iff (rst)
    launch_vld |-> !(dq_oe && rem_q != 2'd0));

  // R4: data output that starts from idle is preceded by a preamble cycle
  assert_preamble_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> ($past(rdqs_oe) && $past(rdqs) == STROBE_PRE));

endmodule

// File: rtl/rdseq_prech_track.sv
module rdseq_prech_track #(
  parameter int BANK_W   = 2,
  parameter int NBANK    = 4,
  parameter int TRAS_MIN = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [BANK_W-1:0] acc_bank,
  input  logic              acc_ap,
  input  logic              last_ap,
  input  logic [BANK_W-1:0] last_bank,
  output logic [NBANK-1:0]  bank_pend,
  output logic [NBANK-1:0]  prech
);

  localparam int AGE_W = $clog2(TRAS_MIN + 1);

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic             done_q;
      logic [AGE_W-1:0] age_q;
      logic             ends_now;
      logic             fire;

      assign ends_now = last_ap && (last_bank == BANK_W'(b));
      assign fire     = bank_pend[b] && (done_q || ends_now)
                        && (age_q >= AGE_W'(TRAS_MIN - 1));

      always_ff @(posedge clk) begin
        if (rst) begin
          bank_pend[b] <= 1'b0;
          prech[b]     <= 1'b0;
          done_q       <= 1'b0;
          age_q        <= '0;
        end else begin
          prech[b] <= fire;
          if (age_q < AGE_W'(TRAS_MIN)) age_q <= age_q + AGE_W'(1);
          if (ends_now) done_q <= 1'b1;
          if (fire) bank_pend[b] <= 1'b0;
          if (accept && acc_ap && acc_bank == BANK_W'(b)) begin
            bank_pend[b] <= 1'b1;
            done_q       <= 1'b0;
            age_q        <= AGE_W'(1);
          end
        end
      end

      // R9: each precharge pulse lasts one cycle
      assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        prech[b] |=> !prech[b]);
    end
  endgenerate

  // R9: pulses for different banks never coincide under a fixed configuration
  assert_prech_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(prech));

endmodule

// File: rtl/ddr_rd_burst_seq.sv
module ddr_rd_burst_seq
  import rdseq_pkg::*;
#(
  parameter int            DW        = 16,
  parameter int            BANK_W    = 2,
  parameter int            COL_W     = 8,
  parameter int            MIN_CL    = 5,
  parameter int            MAX_CL    = 9,
  parameter int            TRAS_MIN  = 12,
  parameter logic [DW-1:0] DATA_SEED = 16'h5A00,
  parameter int            CL_W      = $clog2(MAX_CL + 1),
  parameter int            NBANK     = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CL_W-1:0]   cfg_cas_lat,
  input  logic              cfg_bl8,
  input  logic              cmd_read,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic              cmd_ap,
  output logic [DW-1:0]     dq_rise,
  output logic [DW-1:0]     dq_fall,
  output logic              dq_oe,
  output logic [1:0]        rdqs,
  output logic              rdqs_oe,
  output logic              odt_off,
  output logic [NBANK-1:0]  prech,
  output logic              cmd_err
);

  localparam int CMD_W = BANK_W + COL_W + 1;
  localparam int DEPTH = MAX_CL - 1;

  logic              accept;
  logic [NBANK-1:0]  bank_pend;
  logic              launch_vld, pre_vld;
  logic [CMD_W-1:0]  launch_data;
  logic              last_ap;
  logic [BANK_W-1:0] last_bank;

  rdseq_cmd_gate #(.BANK_W(BANK_W), .NBANK(NBANK)) u_gate (
    .clk(clk), .rst(rst), .cfg_bl8(cfg_bl8), .cmd_read(cmd_read),
    .cmd_bank(cmd_bank), .bank_pend(bank_pend), .accept(accept),
    .cmd_err(cmd_err)
  );

  rdseq_delay_line #(.W(CMD_W), .DEPTH(DEPTH), .SEL_W(CL_W)) u_delay (
    .clk(clk), .rst(rst), .in_vld(accept),
    .in_data({cmd_bank, cmd_col, cmd_ap}),
    .launch_tap(cfg_cas_lat - CL_W'(1)), .pre_tap(cfg_cas_lat - CL_W'(2)),
    .launch_vld(launch_vld), .launch_data(launch_data), .pre_vld(pre_vld)
  );

  rdseq_burst_engine #(.DW(DW), .BANK_W(BANK_W), .COL_W(COL_W),
                       .DATA_SEED(DATA_SEED)) u_engine (
    .clk(clk), .rst(rst), .cfg_bl8(cfg_bl8), .launch_vld(launch_vld),
    .launch_bank(launch_data[CMD_W-1 -: BANK_W]),
    .launch_col(launch_data[COL_W:1]), .launch_ap(launch_data[0]),
    .pre_vld(pre_vld), .dq_rise(dq_rise), .dq_fall(dq_fall), .dq_oe(dq_oe),
    .rdqs(rdqs), .rdqs_oe(rdqs_oe), .odt_off(odt_off),
    .last_ap(last_ap), .last_bank(last_bank)
  );

  rdseq_prech_track #(.BANK_W(BANK_W), .NBANK(NBANK), .TRAS_MIN(TRAS_MIN)) u_prech (
    .clk(clk), .rst(rst), .accept(accept), .acc_bank(cmd_bank), .acc_ap(cmd_ap),
    .last_ap(last_ap), .last_bank(last_bank), .bank_pend(bank_pend),
    .prech(prech)
  );

  // R1: latency configuration stays inside its legal range
  assert_cl_range_R1: assert property (@(posedge clk) disable iff (rst)
    (cfg_cas_lat >= CL_W'(MIN_CL)) && (cfg_cas_lat <= CL_W'(MAX_CL)));

  // R7: terminators are off whenever data or strobe is driven
  assert_odt_cover_R7: assert property (@(posedge clk) disable iff (rst)
    (dq_oe || rdqs_oe) |-> odt_off);

endmodule

// File: tb/test_ddr_rd_burst_seq.sv
`timescale 1ns/1ps
module test_ddr_rd_burst_seq;

  localparam int DW = 16, BANK_W = 2, COL_W = 8, NB = 4, TRAS = 12, NC = 4096;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [3:0]        cfg_cas_lat = 4'd5;
  logic              cfg_bl8 = 1'b0;
  logic              cmd_read = 1'b0;
  logic [BANK_W-1:0] cmd_bank = '0;
  logic [COL_W-1:0]  cmd_col = '0;
  logic              cmd_ap = 1'b0;
  logic [DW-1:0]     dq_rise, dq_fall;
  logic              dq_oe, rdqs_oe, odt_off, cmd_err;
  logic [1:0]        rdqs;
  logic [NB-1:0]     prech;

  always #2.5 clk = ~clk;

  ddr_rd_burst_seq i_ddr_rd_burst_seq (
    .clk(clk), .rst(rst), .cfg_cas_lat(cfg_cas_lat), .cfg_bl8(cfg_bl8),
    .cmd_read(cmd_read), .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_ap(cmd_ap),
    .dq_rise(dq_rise), .dq_fall(dq_fall), .dq_oe(dq_oe), .rdqs(rdqs),
    .rdqs_oe(rdqs_oe), .odt_off(odt_off), .prech(prech), .cmd_err(cmd_err)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  checks = 0, errors = 0;
  bit  done = 1'b0;
  int  cl = 5;
  bit  bl8 = 1'b0;
  int  last_acc = -100;
  int  pend_until [NB];

  logic          e_oe [NC], e_soe [NC], e_odt [NC], e_err [NC];
  logic [DW-1:0] e_r [NC], e_f [NC];
  logic [1:0]    e_sq [NC];
  logic [NB-1:0] e_pr [NC];
  string         e_tag [NC];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp, int n);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, n, act, exp);
    end
  endtask

  function automatic logic [COL_W-1:0] colx(int s, int e);
    int m = bl8 ? 7 : 3;
    return COL_W'((s & ~m) | ((s + e) & m));
  endfunction

  function automatic logic [DW-1:0] word(int b, logic [COL_W-1:0] c);
    return DW'((b << COL_W) | int'(c)) ^ 16'h5A00;
  endfunction

  task automatic check_now(int n);
    string t;
    if (e_oe[n]) t = (n > 0 && e_oe[n-1]) ? "R5" : "R1";
    else         t = e_soe[n] ? "R4" : "R6";
    chk(t, dq_oe, e_oe[n], n);
    chk(t, rdqs_oe, e_soe[n], n);
    chk(e_oe[n] ? "R3" : t, rdqs, e_sq[n], n);
    chk(e_oe[n] ? "R2" : "R6", dq_rise, e_r[n], n);
    chk(e_oe[n] ? "R2" : "R6", dq_fall, e_f[n], n);
    chk("R7", odt_off, e_odt[n], n);
    chk(e_err[n] ? e_tag[n] : "R8", cmd_err, e_err[n], n);
    chk("R9", prech, e_pr[n], n);
  endtask

  task automatic model_cmd(int n, int b, int c, bit ap);
    int  bp = bl8 ? 4 : 2;
    bit  sp_ok = (n - last_acc) >= bp;
    bit  bk_ok = n >= pend_until[b];
    if (sp_ok && bk_ok) begin
      last_acc = n;
      for (int p = 0; p < bp; p++) begin
        int k = n + cl + p;
        e_oe[k] = 1; e_soe[k] = 1; e_odt[k] = 1; e_sq[k] = 2'b10;
        e_r[k] = word(b, colx(c, 2*p));
        e_f[k] = word(b, colx(c, 2*p + 1));
      end
      if (!e_oe[n+cl-1]) begin
        e_soe[n+cl-1] = 1; e_odt[n+cl-1] = 1; e_sq[n+cl-1] = 2'b00;
      end
      if (ap) begin
        int pc = (cl + bp > TRAS) ? n + cl + bp : n + TRAS;
        pend_until[b] = pc;
        e_pr[pc][b] = 1'b1;
      end
    end else begin
      e_err[n+1] = 1'b1;
      e_tag[n+1] = sp_ok ? "R10" : "R8";
    end
  endtask

  task automatic tick(bit rd = 0, int b = 0, int c = 0, bit ap = 0);
    @(negedge clk);
    if (!rst) check_now(cyc);
    cmd_read = rd;
    cmd_bank = rd ? BANK_W'(b) : '0;
    cmd_col  = rd ? COL_W'(c) : '0;
    cmd_ap   = rd ? ap : 1'b0;
    if (rd && !rst) model_cmd(cyc, b, c, ap);
  endtask

  task automatic drain();
    repeat (40) tick();
  endtask

  task automatic set_cfg(int l, bit b8);
    cl = l; bl8 = b8;
    cfg_cas_lat = 4'(l); cfg_bl8 = b8;
  endtask

  initial begin
    for (int i = 0; i < NC; i++) begin
      e_oe[i] = 0; e_soe[i] = 0; e_odt[i] = 0; e_err[i] = 0;
      e_r[i] = '0; e_f[i] = '0; e_sq[i] = '0; e_pr[i] = '0; e_tag[i] = "R8";
    end
    for (int b = 0; b < NB; b++) pend_until[b] = 0;
    void'($urandom(32'd7321));

    // R11: reset state
    repeat (4) begin
      @(negedge clk);
      chk("R11", {dq_oe, rdqs_oe, odt_off, cmd_err, |prech, |rdqs, |dq_rise, |dq_fall},
          64'd0, cyc);
    end
    rst = 1'b0;
    drain();

    // minimum latency, BL4, back-to-back every 2 cycles
    set_cfg(5, 1'b0);
    for (int i = 0; i < 5; i++) begin
      tick(1, i % 4, 8*i + 1, 0);
      tick();
    end
    drain();

    // maximum latency, BL8, gapless, start column mid-block, auto precharge on last
    set_cfg(9, 1'b1);
    for (int i = 0; i < 4; i++) begin
      tick(1, i, 16*i + 5, i == 3);
      repeat (3) tick();
    end
    drain();

    // one-cycle gap (preamble between bursts), then too-early commands
    set_cfg(7, 1'b1);
    tick(1, 0, 2, 0);
    repeat (4) tick();
    tick(1, 1, 9, 0);
    tick(1, 2, 3, 0);
    tick();
    tick(1, 2, 4, 0);
    drain();

    // auto precharge with row-active limit dominant and pending-bank rejection
    set_cfg(6, 1'b0);
    tick(1, 1, 12, 1);
    repeat (3) tick();
    tick(1, 1, 20, 0);
    tick();
    tick(1, 2, 30, 1);
    repeat (6) tick();
    tick(1, 1, 40, 0);
    drain();

    // random phases
    for (int ph = 0; ph < 5; ph++) begin
      set_cfg(5 + int'($urandom % 5), bit'($urandom % 2));
      for (int i = 0; i < 250; i++) begin
        if ($urandom % 2 == 0)
          tick(1, int'($urandom % NB), int'($urandom % 256), ($urandom % 4) == 0);
        else
          tick();
      end
      drain();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule